// File: doc/BRIEF.md
# Ultrasonic Echo Pulse Timer

This block fires a fixed-length trigger pulse at an ultrasonic ranging sensor and then times the echo pulse that the sensor sends back. The trigger starts when the start input is high for a clock while no trigger is in flight. A prescaler turns the system clock into one-microsecond ticks. Those ticks drive a 16-bit timebase that wraps at a reload value given on an input port. The echo input crosses into the clock domain through a two-flop synchroniser. A two-state machine then stamps the timebase on the rising edge of the echo and again on the falling edge, and turns the two stamps into a pulse width.

Each completed rise/fall pair writes the width register and steps a free-running completion counter. A consumer polls that counter to see that a fresh reading has arrived. A supervisor counts the microseconds since the last captured rising edge. When that count reaches the timeout, the supervisor sends the machine back to idle and loads the width register with a sentinel value. The same happens when the echo never falls, and when no new measurement has started for a full timeout window.

Top module: `ept_echo_timer`

## Requirements
- R1: After a synchronous active-low reset, `width_o` holds the sentinel (default all ones), `done_cnt_o` is 0, `trig_o` is low and the capture machine waits for a rising edge.
- R2: A high `start_i` sampled while `trig_o` is low raises `trig_o` on that clock edge. `trig_o` stays high for exactly TRIG_US × CLK_PER_US clock cycles.
- R3: A `start_i` seen while `trig_o` is high is ignored. The pulse ends on its original schedule.
- R4: The timebase counts one per CLK_PER_US clock cycles, with its phase counted from reset. Its value is the number of such ticks modulo reload+1: it goes to 0 on the tick after it has reached `reload_i`.
- R5: An echo change first sampled at clock edge n is acted on at edge n+2 (two synchroniser flops, then the edge detector). Each state looks only for its own polarity: rising when idle, falling while waiting.
- R6: At the falling capture, when the fall stamp is strictly greater than the rise stamp, `width_o` becomes fall − rise. `done_cnt_o` steps by one on the same edge.
- R7: When the fall stamp is not greater than the rise stamp, `width_o` becomes (reload − rise) + fall, truncated to 16 bits. When the two stamps are equal the result is the reload value.
- R8: If TIMEOUT_US ticks pass after a rising capture with no falling capture, `width_o` becomes the sentinel and the machine returns to idle. `done_cnt_o` does not change, and the late falling edge is ignored.
- R9: The elapsed count keeps running while idle. A valid reading is replaced by the sentinel TIMEOUT_US ticks after the rising capture that started it.
- R10: When a falling capture and the supervisor expiry fall on the same edge, the measurement wins and the elapsed count restarts from that edge.
- R11: `done_cnt_o` is CNT_W bits wide and wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one trigger pulse |
| reload_i | input | TB_W | Wrap value of the microsecond timebase |
| echo_i | input | 1 | Asynchronous echo line from the sensor |
| trig_o | output | 1 | Trigger pulse to the sensor |
| width_o | output | TB_W | Last echo width in microseconds, or the sentinel |
| done_cnt_o | output | CNT_W | Free-running count of completed measurements |

## Verification
Two functions can act on the same clock edge: the falling-edge capture that completes a reading, and the supervisor expiry that would force the sentinel. The bench counts edges from reset, so it knows the tick phase. It predicts the expiry edge of a rising capture and drives an echo whose falling capture lands exactly on that edge. The scoreboard expects a measurement, not a timeout, at that cycle, with the computed width and a stepped counter. It then expects the next idle expiry one full window after that edge, which shows that the elapsed count restarted there.

// File: rtl/ept_pkg.sv
`timescale 1ns/1ps
// Shared types for the echo pulse timer.
package ept_pkg;

    // Capture machine: waiting for the leading or the trailing echo edge.
    typedef enum logic {
        CAP_WAIT_RISE = 1'b0,
        CAP_WAIT_FALL = 1'b1
    } cap_state_t;

endpackage

// File: rtl/ept_timebase.sv
`timescale 1ns/1ps
// Microsecond prescaler and wrapping timebase.
// Assumes CLK_PER_US clock cycles make one microsecond. The timebase
// returns to 0 on the tick after it has reached reload_i.
module ept_timebase #(
    parameter int CLK_PER_US = 250,
    parameter int TB_W       = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TB_W-1:0] reload_i,
    output logic            us_tick_o,
    output logic [TB_W-1:0] tb_o
);

    localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

    generate
        if (CLK_PER_US > 1) begin : g_prescale
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);
            logic [PRE_W-1:0] pre_q;

            // Count clock cycles within one microsecond.
            always_ff @(posedge clk) begin
                if (!rst_n)                pre_q <= '0;
                else if (pre_q == PRE_LAST) pre_q <= '0;
                else                        pre_q <= pre_q + 1'b1;
            end

            assign us_tick_o = (pre_q == PRE_LAST);
        end else begin : g_direct
            assign us_tick_o = 1'b1;
        end
    endgenerate

    // Advance the timebase once per microsecond and wrap at the reload value.
    always_ff @(posedge clk) begin
        if (!rst_n)            tb_o <= '0;
        else if (us_tick_o) begin
            if (tb_o >= reload_i) tb_o <= '0;
            else                  tb_o <= tb_o + 1'b1;
        end
    end

endmodule

// File: rtl/ept_trigger.sv
`timescale 1ns/1ps
// Fixed-length trigger pulse generator.
// Assumes TRIG_CYC >= 1. A start request during a pulse is dropped.
module ept_trigger #(
    parameter int TRIG_CYC = 3750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic trig_o
);

    localparam int            TC_W    = $clog2(TRIG_CYC + 1);
    localparam logic [TC_W-1:0] TC_LAST = TC_W'(TRIG_CYC - 1);

    logic [TC_W-1:0] tcnt_q;

    // Hold the trigger high for TRIG_CYC cycles after an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_o <= 1'b0;
            tcnt_q <= '0;
        end else if (trig_o) begin
            if (tcnt_q == TC_LAST) begin
                trig_o <= 1'b0;
                tcnt_q <= '0;
            end else begin
                tcnt_q <= tcnt_q + 1'b1;
            end
        end else if (start_i) begin
            trig_o <= 1'b1;
            tcnt_q <= '0;
        end
    end

endmodule

// File: rtl/ept_edge_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser plus one history flop for echo edge detection.
// Assumes echo_i is asynchronous to clk. Edge strobes are one cycle long.
module ept_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic echo_i,
    output logic rise_o,
    output logic fall_o
);

    logic [2:0] sh_q;

    // Shift the echo through the synchroniser and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], echo_i};
    end

    assign rise_o =  sh_q[1] & ~sh_q[2];
    assign fall_o = ~sh_q[1] &  sh_q[2];

endmodule

// File: rtl/ept_capture.sv
`timescale 1ns/1ps
// Rise/fall capture machine, width arithmetic and timeout supervisor.
// Assumes one-cycle edge strobes and a one-cycle microsecond tick.
// An edge takes precedence over a supervisor expiry on the same cycle.
module ept_capture
    import ept_pkg::*;
#(
    parameter int              TB_W       = 16,
    parameter int              CNT_W      = 8,
    parameter int              TIMEOUT_US = 100000,
    parameter logic [TB_W-1:0] SENTINEL   = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick_i,
    input  logic [TB_W-1:0]  tb_i,
    input  logic [TB_W-1:0]  reload_i,
    input  logic             rise_i,
    input  logic             fall_i,
    output logic [TB_W-1:0]  width_o,
    output logic [CNT_W-1:0] done_cnt_o
);

    localparam int              EL_W    = $clog2(TIMEOUT_US + 1);
    localparam logic [EL_W-1:0] EL_LAST = EL_W'(TIMEOUT_US - 1);

    cap_state_t      state_q;
    logic [TB_W-1:0] rise_st_q;
    logic [EL_W-1:0] elapsed_q;
    logic [TB_W-1:0] width_calc;
    logic            expire;

    // Supervisor fires on the tick that completes the timeout window.
    assign expire = us_tick_i && (elapsed_q == EL_LAST);

    // Width from the stored rise stamp and the live timebase, wrap-corrected.
    always_comb begin
        if (tb_i > rise_st_q) width_calc = tb_i - rise_st_q;
        else                  width_calc = (reload_i - rise_st_q) + tb_i;
    end

    // Capture state, stamps, result, completion count and elapsed time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= CAP_WAIT_RISE;
            rise_st_q  <= '0;
            elapsed_q  <= '0;
            width_o    <= SENTINEL;
            done_cnt_o <= '0;
        end else begin
            case (state_q)
                CAP_WAIT_RISE: begin
                    if (rise_i) begin
                        rise_st_q <= tb_i;
                        elapsed_q <= '0;
                        state_q   <= CAP_WAIT_FALL;
                    end else if (expire) begin
                        rise_st_q <= '0;
                        elapsed_q <= '0;
                        width_o   <= SENTINEL;
                    end else if (us_tick_i) begin
                        elapsed_q <= elapsed_q + 1'b1;
                    end
                end
                CAP_WAIT_FALL: begin
                    if (fall_i) begin
                        width_o    <= width_calc;
                        done_cnt_o <= done_cnt_o + 1'b1;
                        state_q    <= CAP_WAIT_RISE;
                        if (expire)         elapsed_q <= '0;
                        else if (us_tick_i) elapsed_q <= elapsed_q + 1'b1;
                    end else if (expire) begin
                        rise_st_q <= '0;
                        elapsed_q <= '0;
                        width_o   <= SENTINEL;
                        state_q   <= CAP_WAIT_RISE;
                    end else if (us_tick_i) begin
                        elapsed_q <= elapsed_q + 1'b1;
                    end
                end
                default: state_q <= CAP_WAIT_RISE;
            endcase
        end
    end

endmodule

// File: rtl/ept_echo_timer.sv
`timescale 1ns/1ps
// Ultrasonic echo pulse timer: trigger generator, microsecond timebase,
// echo synchroniser and capture machine with a timeout supervisor.
// Assumes echo_i is asynchronous and reload_i is quasi-static.
module ept_echo_timer #(
    parameter int              CLK_PER_US = 250,
    parameter int              TRIG_US    = 15,
    parameter int              TIMEOUT_US = 100000,
    parameter int              TB_W       = 16,
    parameter int              CNT_W      = 8,
    parameter logic [TB_W-1:0] SENTINEL   = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [TB_W-1:0]  reload_i,
    input  logic             echo_i,
    output logic             trig_o,
    output logic [TB_W-1:0]  width_o,
    output logic [CNT_W-1:0] done_cnt_o
);

    localparam int TRIG_CYC = TRIG_US * CLK_PER_US;

    logic            us_tick;
    logic [TB_W-1:0] tb_val;
    logic            echo_rise;
    logic            echo_fall;

    ept_timebase #(
        .CLK_PER_US (CLK_PER_US),
        .TB_W       (TB_W)
    ) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload_i  (reload_i),
        .us_tick_o (us_tick),
        .tb_o      (tb_val)
    );

    ept_trigger #(
        .TRIG_CYC (TRIG_CYC)
    ) u_trigger (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .trig_o  (trig_o)
    );

    ept_edge_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .echo_i (echo_i),
        .rise_o (echo_rise),
        .fall_o (echo_fall)
    );

    ept_capture #(
        .TB_W       (TB_W),
        .CNT_W      (CNT_W),
        .TIMEOUT_US (TIMEOUT_US),
        .SENTINEL   (SENTINEL)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .us_tick_i  (us_tick),
        .tb_i       (tb_val),
        .reload_i   (reload_i),
        .rise_i     (echo_rise),
        .fall_i     (echo_fall),
        .width_o    (width_o),
        .done_cnt_o (done_cnt_o)
    );

endmodule

// File: rtl/ept_echo_timer_chk.sv
`timescale 1ns/1ps
// Property checker for the echo pulse timer, observing top-level ports only.
// Assumes reset is asserted from time zero.
module ept_echo_timer_chk #(
    parameter int              TRIG_CYC = 3750,
    parameter int              TB_W     = 16,
    parameter int              CNT_W    = 8,
    parameter logic [TB_W-1:0] SENTINEL = '1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_o,
    input logic [TB_W-1:0]  width_o,
    input logic [CNT_W-1:0] done_cnt_o
);

    localparam int HL_W = $clog2(TRIG_CYC + 2);

    logic [HL_W-1:0] hi_len_q;

    // Count consecutive sampled-high cycles of the trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_len_q <= '0;
        else if (trig_o) hi_len_q <= hi_len_q + 1'b1;
        else             hi_len_q <= '0;
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (width_o == SENTINEL && done_cnt_o == '0 && !trig_o)); // R1

    AST_TRIG_EXACT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trig_o) |-> hi_len_q == HL_W'(TRIG_CYC)); // R2

    AST_TRIG_NOT_EXTENDED: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> hi_len_q < HL_W'(TRIG_CYC)); // R3

    AST_COUNT_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done_cnt_o != $past(done_cnt_o)) |-> done_cnt_o == CNT_W'($past(done_cnt_o) + 1'b1)); // R11

    AST_RESULT_WITH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (width_o != $past(width_o) && width_o != SENTINEL) |-> done_cnt_o != $past(done_cnt_o)); // R6

endmodule

bind ept_echo_timer ept_echo_timer_chk #(
    .TRIG_CYC (TRIG_CYC),
    .TB_W     (TB_W),
    .CNT_W    (CNT_W),
    .SENTINEL (SENTINEL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_o     (trig_o),
    .width_o    (width_o),
    .done_cnt_o (done_cnt_o)
);

// File: tb/test_ept_echo_timer.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected events, a monitor records
// observed width/count events and compares them in order with cycle stamps.
module test_ept_echo_timer;

    localparam int P       = 2;
    localparam int T       = 300;
    localparam int TRIG_US = 15;
    localparam int CNT_W   = 4;
    localparam int CNTMOD  = 1 << CNT_W;
    localparam int SENT    = 16'hFFFF;
    localparam int K_MEAS  = 0;
    localparam int K_TMO   = 1;
    localparam int K_ODD   = 2;

    typedef struct {
        int    kind;
        int    width;
        int    cnt;
        int    at;
        string req;
    } evt_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [15:0]      reload_i = 16'hFFFF;
    logic             echo_i = 1'b0;
    logic             trig_o;
    logic [15:0]      width_o;
    logic [CNT_W-1:0] done_cnt_o;

    int vecs = 0;
    int miss = 0;
    int cyc  = 0;

    evt_t exp_q[$];
    evt_t obs_q[$];

    // Bench-side model of the requirements.
    int clr_edge  = 0;
    bit valid     = 1'b0;
    int exp_cnt   = 0;
    int reload_m  = 16'hFFFF;

    ept_echo_timer #(
        .CLK_PER_US (P),
        .TRIG_US    (TRIG_US),
        .TIMEOUT_US (T),
        .TB_W       (16),
        .CNT_W      (CNT_W)
    ) i_ept_echo_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .reload_i   (reload_i),
        .echo_i     (echo_i),
        .trig_o     (trig_o),
        .width_o    (width_o),
        .done_cnt_o (done_cnt_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    function automatic int tbv(input int n);
        return ((n - 1) / P) % (reload_m + 1);
    endfunction

    function automatic int expiry_after(input int e);
        return (e / P + T) * P;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            miss++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int kind, input int w, input int c, input int at, input string req);
        evt_t e;
        e.kind = kind; e.width = w; e.cnt = c; e.at = at; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic do_reset(input int rl);
        @(negedge clk);
        rst_n = 1'b0;
        reload_i = rl[15:0];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        clr_edge = 0; valid = 1'b0; exp_cnt = 0; reload_m = rl;
    endtask

    // Drive one echo pulse starting right after a negedge; predict its events.
    task automatic echo_pulse(input int hi, input int lo, input string req);
        int c, f, x, x0, rs, fs, w;
        echo_i = 1'b1;
        c = cyc + 3;
        if (valid) begin
            x0 = expiry_after(clr_edge);
            if (x0 < c) begin
                push(K_TMO, SENT, exp_cnt, x0, "R9");
                valid = 1'b0;
            end
        end
        clr_edge = c;
        x = expiry_after(c);
        repeat (hi) @(negedge clk);
        echo_i = 1'b0;
        f = cyc + 3;
        if (f <= x) begin
            rs = tbv(c);
            fs = tbv(f);
            w  = (fs > rs) ? fs - rs : ((reload_m - rs) + fs) & 16'hFFFF;
            exp_cnt = (exp_cnt + 1) % CNTMOD;
            push(K_MEAS, w, exp_cnt, f, req);
            valid = 1'b1;
            clr_edge = (f == x) ? f : c;
        end else begin
            if (valid) push(K_TMO, SENT, exp_cnt, x, req);
            valid = 1'b0;
            clr_edge = x;
        end
        repeat (lo) @(negedge clk);
    endtask

    // Let the pending idle expiry happen and expect it.
    task automatic settle(input string req);
        int xi;
        if (valid) begin
            xi = expiry_after(clr_edge);
            push(K_TMO, SENT, exp_cnt, xi, req);
            valid = 1'b0;
            while (cyc < xi + 2) @(negedge clk);
        end else begin
            repeat (8) @(negedge clk);
        end
    endtask

    // Monitor: record events at the ports and compare them with expectations.
    initial begin
        int   prev_w;
        int   prev_c;
        evt_t o, e;
        prev_w = SENT;
        prev_c = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                prev_w = SENT;
                prev_c = 0;
            end else begin
                o.width = int'(width_o);
                o.cnt   = int'(done_cnt_o);
                o.at    = cyc;
                o.req   = "";
                if (o.cnt != prev_c) begin
                    o.kind = K_MEAS; obs_q.push_back(o);
                end else if (o.width == SENT && prev_w != SENT) begin
                    o.kind = K_TMO; obs_q.push_back(o);
                end else if (o.width != prev_w) begin
                    o.kind = K_ODD; obs_q.push_back(o);
                end
                prev_w = o.width;
                prev_c = o.cnt;
                while (exp_q.size() > 0 && obs_q.size() > 0) begin
                    e = exp_q.pop_front();
                    o = obs_q.pop_front();
                    check(o.kind == e.kind, {e.req, " kind"}, o.kind, e.kind);
                    check(o.at == e.at, {e.req, " cycle"}, o.at, e.at);
                    if (e.kind == K_MEAS) begin
                        check(o.width == e.width, {e.req, " width"}, o.width, e.width);
                        check(o.cnt == e.cnt, {e.req, " count"}, o.cnt, e.cnt);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 4);
        miss++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        int hc, c_pred, hi;
        do_reset(16'hFFFF);
        @(negedge clk);
        check(width_o == 16'hFFFF, "R1 width", int'(width_o), SENT);
        check(done_cnt_o == '0, "R1 count", int'(done_cnt_o), 0);
        check(trig_o == 1'b0, "R1 trig", int'(trig_o), 0);

        // R2: trigger length.
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        hc = 0;
        while (trig_o && hc < 1000) begin hc++; @(negedge clk); end
        check(hc == TRIG_US * P, "R2 trigger cycles", hc, TRIG_US * P);

        // R3: second start inside the pulse is ignored.
        repeat (4) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        hc = 0;
        for (int k = 0; k < 120; k++) begin
            if (trig_o) hc++;
            if (k == 10) start_i = 1'b1;
            if (k == 11) start_i = 1'b0;
            @(negedge clk);
        end
        check(hc == TRIG_US * P, "R3 trigger cycles", hc, TRIG_US * P);

        // R5, R6: ordinary measurements with distinct lengths.
        echo_pulse(40, 20, "R6");
        echo_pulse(21, 10, "R5");
        echo_pulse(7, 10, "R6");

        // R8: echo stuck high past the window; the late fall is ignored.
        echo_pulse(T * P + 60, 30, "R8");
        check(width_o == 16'hFFFF, "R8 width after late fall", int'(width_o), SENT);
        check(int'(done_cnt_o) == exp_cnt, "R8 count unchanged", int'(done_cnt_o), exp_cnt);

        // R9: a valid reading expires while idle.
        echo_pulse(30, 10, "R9");
        settle("R9");

        // R10: falling capture lands on the expiry edge.
        c_pred = cyc + 3;
        hi = expiry_after(c_pred) - c_pred;
        echo_pulse(hi, 20, "R10");
        settle("R10");

        // R11: burst wraps the completion counter.
        for (int k = 0; k < CNTMOD + 1; k++) echo_pulse(4, 6, "R11");
        settle("R11");

        // R4, R7: small reload forces timebase wrap.
        do_reset(20);
        @(negedge clk);
        check(width_o == 16'hFFFF, "R1 width after reset", int'(width_o), SENT);
        echo_pulse(10, 10, "R4");
        echo_pulse(30, 10, "R7");
        echo_pulse(26, 10, "R7");
        echo_pulse(21 * P, 10, "R7");
        settle("R7");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "pending expected events", exp_q.size(), 0);
        check(obs_q.size() == 0, "unmatched observed events", obs_q.size(), 0);
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

endmodule